// File: doc/BRIEF.md
# Write-Back Cache Site Protocol Engine

This block is the cache controller of one site in a directory-style coherence system. It holds a small direct-mapped cache. Each line keeps a tag, a data word and a protocol state. The processor issues loads and stores through a valid/ready request port and receives the result one cycle after acceptance. A hit is served at once. Any other access stalls the processor while the engine exchanges messages with memory over an incoming message port and an outgoing message port.

On a miss, the engine first clears the slot. A clean victim is dropped by telling memory with a purge notice. A dirty victim is written back and waits in a writeback-in-flight state until memory answers. Memory either lets the site keep a clean copy or orders it to drop the line. Only after that does the engine ask for the new copy. While the request is outstanding, the line sits in a fill-in-flight state and serves nothing. Memory may also ask the site, at any time, to give up a line. The engine answers according to the line's state.

The outgoing port has a single holding register. An incoming message is only taken when that register is empty, because any incoming message may need to send a reply. Incoming traffic has priority over processor requests.

Top module: `wbsite_engine`

## Requirements
- R1: After reset no outgoing message is valid, no response is valid, no request is accepted and no incoming message is taken; every line is invalid.
- R2: A load whose address tag matches a line in the clean or dirty state is accepted in the cycle it is presented, with no message sent. The stored word is returned with the response valid one cycle later.
- R3: A store that hits a clean or dirty line is accepted at once, with no message sent. It replaces the word, marks the line dirty and echoes the written word in the response one cycle later.
- R4: An access to an invalid slot sends a copy request (command 4) carrying the full request address and moves the line to fill-in-flight. The processor stalls, and no response is ever produced from a fill-in-flight line.
- R5: A copy message (command 0) for a fill-in-flight line with matching tag installs the carried word and makes the line clean, so the stalled access then completes with that word.
- R6: An access that conflicts with a clean line of another tag sends a purge notice (command 6) with the victim's address, invalidates the slot, and then issues the copy request.
- R7: An access that conflicts with a dirty line sends a writeback (command 5) with the victim's address and word, moves the line to writeback-in-flight, and stalls until memory answers.
- R8: A keep-clean acknowledge (command 1) turns a writeback-in-flight line clean, so it later hits or is purged. A drop acknowledge (command 2) invalidates the line, so the next conflicting access sends only the copy request.
- R9: A give-up request (command 3) on a clean line sends a purge notice and invalidates the line. On a dirty line it sends a writeback with the word and enters writeback-in-flight.
- R10: A give-up request that finds its line in writeback-in-flight, or finds the address absent, is taken from the incoming port and sends nothing.
- R11: An outgoing message holds command, address and data stable until outReady. An incoming message is not taken while an outgoing message waits, and it takes precedence over the processor when the outgoing slot is empty.
- R12: The line index is the low log2(LINES) address bits and the tag is the rest, so addresses that differ only in tag compete for one line.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqWrite | input | 1 | 1 = store, 0 = load |
| cpuReqAddr | input | ADDR_W | Request address |
| cpuReqData | input | DATA_W | Store data |
| cpuReqReady | output | 1 | Request accepted this cycle |
| cpuRspValid | output | 1 | Response valid |
| cpuRspData | output | DATA_W | Loaded or stored word |
| inValid | input | 1 | Incoming message present |
| inCmd | input | 3 | Incoming command (0 copy, 1 keep-clean ack, 2 drop ack, 3 give-up request) |
| inAddr | input | ADDR_W | Incoming message address |
| inData | input | DATA_W | Incoming message data |
| inReady | output | 1 | Incoming message taken this cycle |
| outValid | output | 1 | Outgoing message present |
| outCmd | output | 3 | Outgoing command (4 copy request, 5 writeback, 6 purge notice) |
| outAddr | output | ADDR_W | Outgoing message address |
| outData | output | DATA_W | Outgoing message data |
| outReady | input | 1 | Outgoing message taken this cycle |

## Verification
The bench goes after the eviction chain where a dirty victim is written back, kept clean by memory, and then must still be purged before the new copy is requested. An engine that treated the keep-clean acknowledge as "slot free" would request the new copy while memory still lists the site as holding the old line. It also sends give-up requests to lines already in writeback-in-flight and to absent lines. A wrong design would emit a second writeback or a stray purge notice. Finally, it stalls the outgoing port with a give-up request queued behind. An engine that took the incoming message anyway would lose its reply or corrupt the held message. The random phase compares every load against the last value stored or held in memory, so a lost writeback or a stale fill shows up as a data mismatch.

// File: rtl/wbsite_pkg.sv
package wbsite_pkg;

  typedef enum logic [2:0] {
    LS_INV    = 3'd0,
    LS_CLEAN  = 3'd1,
    LS_DIRTY  = 3'd2,
    LS_WBPEND = 3'd3,
    LS_CPEND  = 3'd4
  } lineState_e;

  typedef enum logic [2:0] {
    MC_CACHE    = 3'd0,
    MC_WBACK    = 3'd1,
    MC_FLUSHACK = 3'd2,
    MC_PURGEREQ = 3'd3,
    MC_CACHEREQ = 3'd4,
    MC_WB       = 3'd5,
    MC_PURGE    = 3'd6
  } msgCmd_e;

  typedef enum logic [1:0] {
    DS_KEEP = 2'd0,
    DS_CPU  = 2'd1,
    DS_MSG  = 2'd2
  } dataSel_e;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic       fromMsg;    // line addressed by incoming message (1) or processor (0)
    logic       wrLine;
    lineState_e wrState;
    logic       wrTag;
    dataSel_e   dataSel;
    logic       sendMsg;
    msgCmd_e    sendCmd;
    logic       sendVictim; // address from stored tag rather than request tag
    logic       rspFire;
    logic       popIn;
  } strobe_t;

endpackage

// File: rtl/wbsite_dpath.sv
module wbsite_dpath
  import wbsite_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqData,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  input  logic              outReady,
  output logic              outValid,
  output logic [2:0]        outCmd,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  output logic              cpuRspValid,
  output logic [DATA_W-1:0] cpuRspData,
  output lineState_e        cpuLineState,
  output logic              cpuTagHit,
  output lineState_e        msgLineState,
  output logic              msgTagHit
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_e        stateQ [LINES];
  logic [TAG_W-1:0]  tagQ   [LINES];
  logic [DATA_W-1:0] dataQ  [LINES];

  msgCmd_e outCmdQ;

  logic [IDX_W-1:0] cpuIdx, inIdx, selIdx;
  logic [TAG_W-1:0] cpuTag, inTag, selTag;

  assign cpuIdx = cpuReqAddr[IDX_W-1:0];
  assign cpuTag = cpuReqAddr[ADDR_W-1:IDX_W];
  assign inIdx  = inAddr[IDX_W-1:0];
  assign inTag  = inAddr[ADDR_W-1:IDX_W];
  assign selIdx = strb.fromMsg ? inIdx : cpuIdx;
  assign selTag = strb.fromMsg ? inTag : cpuTag;

  assign cpuLineState = stateQ[cpuIdx];
  assign cpuTagHit    = (tagQ[cpuIdx] == cpuTag);
  assign msgLineState = stateQ[inIdx];
  assign msgTagHit    = (tagQ[inIdx] == inTag);
  assign outCmd       = outCmdQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        stateQ[i] <= LS_INV;
        tagQ[i]   <= '0;
        dataQ[i]  <= '0;
      end
      outValid    <= 1'b0;
      outCmdQ     <= MC_CACHEREQ;
      outAddr     <= '0;
      outData     <= '0;
      cpuRspValid <= 1'b0;
      cpuRspData  <= '0;
    end else begin
      if (strb.wrLine) begin
        stateQ[selIdx] <= strb.wrState;
        if (strb.wrTag) tagQ[selIdx] <= selTag;
        case (strb.dataSel)
          DS_CPU:  dataQ[selIdx] <= cpuReqData;
          DS_MSG:  dataQ[selIdx] <= inData;
          default: ;
        endcase
      end
      if (strb.sendMsg) begin
        outValid <= 1'b1;
        outCmdQ  <= strb.sendCmd;
        outAddr  <= strb.sendVictim ? {tagQ[selIdx], selIdx} : {selTag, selIdx};
        outData  <= dataQ[selIdx];
      end else if (outReady) begin
        outValid <= 1'b0;
      end
      cpuRspValid <= strb.rspFire;
      if (strb.rspFire)
        cpuRspData <= cpuReqWrite ? cpuReqData : dataQ[cpuIdx];
    end
  end

  // R11: a waiting outgoing message does not change
  a_r11_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outCmdQ) && $stable(outAddr) && $stable(outData)));

  // R11: a new message is only loaded into an empty slot
  a_r11_send_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    strb.sendMsg |-> !outValid);

  // R4: a response is only produced from a usable line of matching tag
  a_r4_rsp_from_usable: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rspFire |-> (cpuTagHit && (stateQ[cpuIdx] == LS_CLEAN || stateQ[cpuIdx] == LS_DIRTY)));

  // R5: fill data only lands in a line waiting for it
  a_r5_fill_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrLine && strb.dataSel == DS_MSG) |-> (stateQ[selIdx] == LS_CPEND));

  // R1: every line state stays within the legal encodings
  for (genvar g = 0; g < LINES; g++) begin : g_legal
    a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      stateQ[g] <= LS_CPEND);
  end

endmodule

// File: rtl/wbsite_ctrl.sv
module wbsite_ctrl
  import wbsite_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpuReqValid,
  input  logic       cpuReqWrite,
  input  logic       inValid,
  input  logic [2:0] inCmd,
  input  logic       outValid,
  input  lineState_e cpuLineState,
  input  logic       cpuTagHit,
  input  lineState_e msgLineState,
  input  logic       msgTagHit,
  output strobe_t    strb,
  output logic       inReady,
  output logic       cpuReqReady
);

  logic slotFree;
  assign slotFree = !outValid;

  always_comb begin
    strb = '0;
    if (inValid && slotFree) begin
      strb.fromMsg = 1'b1;
      strb.popIn   = 1'b1;
      case (msgCmd_e'(inCmd))
        MC_CACHE: if (msgTagHit && msgLineState == LS_CPEND) begin
          strb.wrLine  = 1'b1;
          strb.wrState = LS_CLEAN;
          strb.dataSel = DS_MSG;
        end
        MC_WBACK: if (msgTagHit && msgLineState == LS_WBPEND) begin
          strb.wrLine  = 1'b1;
          strb.wrState = LS_CLEAN;
        end
        MC_FLUSHACK: if (msgTagHit && msgLineState == LS_WBPEND) begin
          strb.wrLine  = 1'b1;
          strb.wrState = LS_INV;
        end
        MC_PURGEREQ: if (msgTagHit && msgLineState == LS_CLEAN) begin
          strb.wrLine  = 1'b1;
          strb.wrState = LS_INV;
          strb.sendMsg = 1'b1;
          strb.sendCmd = MC_PURGE;
        end else if (msgTagHit && msgLineState == LS_DIRTY) begin
          strb.wrLine  = 1'b1;
          strb.wrState = LS_WBPEND;
          strb.sendMsg = 1'b1;
          strb.sendCmd = MC_WB;
        end
        default: ;
      endcase
    end else if (cpuReqValid) begin
      if (cpuTagHit && (cpuLineState == LS_CLEAN || cpuLineState == LS_DIRTY)) begin
        strb.rspFire = 1'b1;
        if (cpuReqWrite) begin
          strb.wrLine  = 1'b1;
          strb.wrState = LS_DIRTY;
          strb.dataSel = DS_CPU;
        end
      end else if (slotFree) begin
        case (cpuLineState)
          LS_INV: begin
            strb.wrLine  = 1'b1;
            strb.wrState = LS_CPEND;
            strb.wrTag   = 1'b1;
            strb.sendMsg = 1'b1;
            strb.sendCmd = MC_CACHEREQ;
          end
          LS_CLEAN: begin
            strb.wrLine     = 1'b1;
            strb.wrState    = LS_INV;
            strb.sendMsg    = 1'b1;
            strb.sendCmd    = MC_PURGE;
            strb.sendVictim = 1'b1;
          end
          LS_DIRTY: begin
            strb.wrLine     = 1'b1;
            strb.wrState    = LS_WBPEND;
            strb.sendMsg    = 1'b1;
            strb.sendCmd    = MC_WB;
            strb.sendVictim = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign inReady     = strb.popIn;
  assign cpuReqReady = strb.rspFire;

  // R11: an incoming message is never taken while a reply slot is occupied
  a_r11_pop_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |-> !outValid);

  // R11: incoming traffic wins over the processor when both could proceed
  a_r11_in_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !outValid) |-> !cpuReqReady);

endmodule

// File: rtl/wbsite_engine.sv
module wbsite_engine
  import wbsite_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpuReqValid,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqData,
  output logic              cpuReqReady,
  output logic              cpuRspValid,
  output logic [DATA_W-1:0] cpuRspData,
  input  logic              inValid,
  input  logic [2:0]        inCmd,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [2:0]        outCmd,
  output logic [ADDR_W-1:0] outAddr,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);

  strobe_t    strb;
  lineState_e cpuLineState, msgLineState;
  logic       cpuTagHit, msgTagHit;

  wbsite_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpuReqValid  (cpuReqValid),
    .cpuReqWrite  (cpuReqWrite),
    .inValid      (inValid),
    .inCmd        (inCmd),
    .outValid     (outValid),
    .cpuLineState (cpuLineState),
    .cpuTagHit    (cpuTagHit),
    .msgLineState (msgLineState),
    .msgTagHit    (msgTagHit),
    .strb         (strb),
    .inReady      (inReady),
    .cpuReqReady  (cpuReqReady)
  );

  wbsite_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .cpuReqWrite  (cpuReqWrite),
    .cpuReqAddr   (cpuReqAddr),
    .cpuReqData   (cpuReqData),
    .inAddr       (inAddr),
    .inData       (inData),
    .outReady     (outReady),
    .outValid     (outValid),
    .outCmd       (outCmd),
    .outAddr      (outAddr),
    .outData      (outData),
    .cpuRspValid  (cpuRspValid),
    .cpuRspData   (cpuRspData),
    .cpuLineState (cpuLineState),
    .cpuTagHit    (cpuTagHit),
    .msgLineState (msgLineState),
    .msgTagHit    (msgTagHit)
  );

endmodule

// File: tb/wbsite_engine_tb.sv
module wbsite_engine_tb;
  import wbsite_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cpuReqValid, cpuReqWrite;
  logic [AW-1:0] cpuReqAddr;
  logic [DW-1:0] cpuReqData;
  logic cpuReqReady, cpuRspValid;
  logic [DW-1:0] cpuRspData;
  logic inValid;
  logic [2:0] inCmd;
  logic [AW-1:0] inAddr;
  logic [DW-1:0] inData;
  logic inReady, outValid;
  logic [2:0] outCmd;
  logic [AW-1:0] outAddr;
  logic [DW-1:0] outData;
  logic outReady;

  wbsite_engine #(.ADDR_W(AW), .DATA_W(DW), .LINES(8)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpuReqValid(cpuReqValid), .cpuReqWrite(cpuReqWrite), .cpuReqAddr(cpuReqAddr),
    .cpuReqData(cpuReqData), .cpuReqReady(cpuReqReady), .cpuRspValid(cpuRspValid),
    .cpuRspData(cpuRspData), .inValid(inValid), .inCmd(inCmd), .inAddr(inAddr),
    .inData(inData), .inReady(inReady), .outValid(outValid), .outCmd(outCmd),
    .outAddr(outAddr), .outData(outData), .outReady(outReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0, nFail = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];

  // incoming queue model
  logic [2:0]    qCmd [16];
  logic [AW-1:0] qAddr [16];
  logic [DW-1:0] qData [16];
  int qHead = 0, qTail = 0;

  // log of outgoing messages
  logic [2:0]    logCmd [64];
  logic [AW-1:0] logAddr [64];
  logic [DW-1:0] logData [64];
  int outCount = 0;

  bit autoMem = 0, manualOutReady = 1;
  bit inFire = 0, outFire = 0;
  logic [2:0] capCmd;
  logic [AW-1:0] capAddr;
  logic [DW-1:0] capData;

  bit cpuBusy = 0, lastRspOk;
  logic [DW-1:0] lastRd;
  int waitN;

  function automatic logic [DW-1:0] memInit(input int a);
    return {a[7:0], ~a[7:0]} ^ 16'h5A3C;
  endfunction

  function automatic void push(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    qCmd[qTail & 15] = c;
    qAddr[qTail & 15] = a;
    qData[qTail & 15] = d;
    qTail++;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  // memory side: consumes outgoing messages and drives the incoming queue
  initial begin
    inValid = 0; inCmd = 0; inAddr = 0; inData = 0; outReady = 0;
    forever begin
      @(negedge clk);
      if (inFire) qHead++;
      if (outFire) begin
        logCmd[outCount & 63] = capCmd;
        logAddr[outCount & 63] = capAddr;
        logData[outCount & 63] = capData;
        outCount++;
        if (capCmd == MC_WB) mem[capAddr] = capData;
        if (autoMem) begin
          if (capCmd == MC_CACHEREQ) push(MC_CACHE, capAddr, mem[capAddr]);
          if (capCmd == MC_WB) push(($urandom % 2) ? MC_WBACK : MC_FLUSHACK, capAddr, '0);
        end
      end
      if (autoMem && qHead == qTail && ($urandom % 12) == 0)
        push(MC_PURGEREQ, AW'($urandom % 32), '0);
      inValid = (qHead != qTail);
      inCmd   = qCmd[qHead & 15];
      inAddr  = qAddr[qHead & 15];
      inData  = qData[qHead & 15];
      outReady = autoMem ? (($urandom % 4) != 0) : manualOutReady;
      #1;
      inFire  = inValid && inReady;
      outFire = outValid && outReady;
      capCmd = outCmd; capAddr = outAddr; capData = outData;
    end
  end

  task automatic cpuOp(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cpuBusy = 1;
    @(negedge clk);
    cpuReqValid = 1; cpuReqWrite = wr; cpuReqAddr = a; cpuReqData = d;
    waitN = 0;
    forever begin
      #1;
      if (cpuReqReady) break;
      @(negedge clk);
      waitN++;
    end
    @(negedge clk);
    cpuReqValid = 0;
    lastRspOk = cpuRspValid;
    lastRd = cpuRspData;
    if (wr) shadow[a] = d;
    cpuBusy = 0;
  endtask

  task automatic pushIn(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    #2;
    push(c, a, d);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkLog(input int idx, input logic [2:0] c, input logic [AW-1:0] a, input string req);
    check(logCmd[idx & 63] == c && logAddr[idx & 63] == a, req,
          {logCmd[idx & 63], logAddr[idx & 63]}, {c, a});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      mem[i] = memInit(i);
      shadow[i] = memInit(i);
    end
    rst_n = 0; cpuReqValid = 0; cpuReqWrite = 0; cpuReqAddr = 0; cpuReqData = 0;
    waitCycles(3);
    rst_n = 1;
    #3;
    // R1 reset state
    check(!outValid && !cpuRspValid && !inReady && !cpuReqReady, "R1",
          {outValid, cpuRspValid, inReady, cpuReqReady}, 0);

    // R4 miss on empty line, R5 fill
    base = outCount;
    fork cpuOp(0, 8'h05, '0); join_none
    waitCycles(5);
    check(outCount == base + 1, "R4 one request", outCount - base, 1);
    checkLog(base, MC_CACHEREQ, 8'h05, "R4 copy request");
    check(cpuBusy, "R4 stall", cpuBusy, 1);
    pushIn(MC_CACHE, 8'h05, mem[8'h05]);
    wait (!cpuBusy);
    check(lastRspOk && lastRd == shadow[8'h05], "R5", lastRd, shadow[8'h05]);

    // R2 load hit
    base = outCount;
    cpuOp(0, 8'h05, '0);
    check(waitN == 0 && lastRspOk, "R2 immediate", waitN, 0);
    check(lastRd == shadow[8'h05], "R2 data", lastRd, shadow[8'h05]);
    check(outCount == base, "R2 no message", outCount - base, 0);

    // R3 store hit
    cpuOp(1, 8'h05, 16'hBEEF);
    check(waitN == 0 && lastRspOk && lastRd == 16'hBEEF, "R3 echo", lastRd, 16'hBEEF);
    cpuOp(0, 8'h05, '0);
    check(lastRd == 16'hBEEF && outCount == base, "R3 readback", lastRd, 16'hBEEF);

    // R7 dirty victim, R8 keep-clean ack, R6 clean victim, R12 same index
    base = outCount;
    fork cpuOp(0, 8'h0D, '0); join_none
    waitCycles(5);
    checkLog(base, MC_WB, 8'h05, "R7 writeback");
    check(logData[base & 63] == 16'hBEEF, "R7 data", logData[base & 63], 16'hBEEF);
    check(cpuBusy && outCount == base + 1, "R7 stall", outCount - base, 1);
    pushIn(MC_WBACK, 8'h05, '0);
    waitCycles(8);
    check(outCount == base + 3, "R8 keep-clean then purge", outCount - base, 3);
    checkLog(base + 1, MC_PURGE, 8'h05, "R6 purge victim");
    checkLog(base + 2, MC_CACHEREQ, 8'h0D, "R6 then request");
    pushIn(MC_CACHE, 8'h0D, mem[8'h0D]);
    wait (!cpuBusy);
    check(lastRd == shadow[8'h0D], "R12 tag select", lastRd, shadow[8'h0D]);

    // R8 drop ack
    cpuOp(1, 8'h0D, 16'h1111);
    base = outCount;
    fork cpuOp(0, 8'h15, '0); join_none
    waitCycles(5);
    checkLog(base, MC_WB, 8'h0D, "R7 second writeback");
    pushIn(MC_FLUSHACK, 8'h0D, '0);
    waitCycles(8);
    check(outCount == base + 2, "R8 drop then request only", outCount - base, 2);
    checkLog(base + 1, MC_CACHEREQ, 8'h15, "R8 request after drop");
    pushIn(MC_CACHE, 8'h15, mem[8'h15]);
    wait (!cpuBusy);
    check(lastRd == shadow[8'h15], "R5 fill", lastRd, shadow[8'h15]);

    // R9 give-up on clean
    base = outCount;
    pushIn(MC_PURGEREQ, 8'h15, '0);
    waitCycles(6);
    check(outCount == base + 1, "R9 one reply", outCount - base, 1);
    checkLog(base, MC_PURGE, 8'h15, "R9 purge reply");
    fork cpuOp(0, 8'h15, '0); join_none
    waitCycles(5);
    checkLog(base + 1, MC_CACHEREQ, 8'h15, "R9 line dropped");
    pushIn(MC_CACHE, 8'h15, mem[8'h15]);
    wait (!cpuBusy);
    check(lastRd == shadow[8'h15], "R9 refill", lastRd, shadow[8'h15]);

    // R9 give-up on dirty, R10 ignored cases
    cpuOp(1, 8'h15, 16'h4444);
    base = outCount;
    pushIn(MC_PURGEREQ, 8'h15, '0);
    waitCycles(6);
    checkLog(base, MC_WB, 8'h15, "R9 dirty writeback");
    check(logData[base & 63] == 16'h4444, "R9 dirty data", logData[base & 63], 16'h4444);
    pushIn(MC_PURGEREQ, 8'h15, '0);
    pushIn(MC_PURGEREQ, 8'h03, '0);
    waitCycles(8);
    check(outCount == base + 1, "R10 nothing sent", outCount - base, 1);
    check(qHead == qTail, "R10 consumed", qTail - qHead, 0);
    pushIn(MC_WBACK, 8'h15, '0);
    waitCycles(4);
    base = outCount;
    cpuOp(0, 8'h15, '0);
    check(waitN == 0 && lastRd == 16'h4444 && outCount == base, "R8 kept clean hit", lastRd, 16'h4444);

    // R11 hold and incoming blocked
    manualOutReady = 0;
    base = outCount;
    fork cpuOp(0, 8'h02, '0); join_none
    waitCycles(3);
    repeat (4) begin
      @(negedge clk);
      #3;
      check(outValid && outCmd == MC_CACHEREQ && outAddr == 8'h02, "R11 hold",
            {outValid, outCmd, outAddr}, {1'b1, 3'(MC_CACHEREQ), 8'h02});
    end
    pushIn(MC_PURGEREQ, 8'h15, '0);
    waitCycles(4);
    check(qTail - qHead == 1, "R11 incoming held", qTail - qHead, 1);
    manualOutReady = 1;
    waitCycles(8);
    checkLog(base, MC_CACHEREQ, 8'h02, "R11 first out");
    checkLog(base + 1, MC_PURGE, 8'h15, "R11 then reply");
    pushIn(MC_CACHE, 8'h02, mem[8'h02]);
    wait (!cpuBusy);
    check(lastRd == shadow[8'h02], "R11 fill after hold", lastRd, shadow[8'h02]);

    // random phase: loads compared against last written value (R2 R3 R12)
    autoMem = 1;
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      bit wr;
      logic [DW-1:0] d;
      a = AW'($urandom % 32);
      wr = ($urandom % 3) == 0;
      d = DW'($urandom);
      cpuOp(wr, a, d);
      if (!wr) check(lastRspOk && lastRd == shadow[a], "R2 random load", lastRd, shadow[a]);
      else     check(lastRspOk && lastRd == d, "R3 random store", lastRd, d);
    end
    autoMem = 0;
    waitCycles(4);
    summary();
    $finish;
  end

endmodule